// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI host that runs exactly one flash transaction per trigger. Software stores an opcode in its own register. It also stores how many bytes follow the opcode, how many bytes to read back, and the outgoing bytes, which go into a single shared byte FIFO. A trigger write then starts the engine. It selects the flash and shifts out the opcode and the outgoing bytes. It then clocks in the requested number of bytes and releases the select line.

Received bytes land in the same FIFO, directly behind the transmitted ones, so software reads them starting at entry `tx_count`. Opcodes are screened against a parameterised allow-list. A screened-out opcode raises an illegal-access flag, and the trigger is refused.

The register interface is byte-wide. Writes are taken on the clock edge, and read data is a combinational decode of `reg_addr`. The serial side runs in SPI mode 0, with the SCK half period a parameter counted in core clocks.

Top module: `sfce_top`

## Requirements
- R1: After reset, chip select is high, SCK is low, both busy bits read 0, and the illegal bit reads 1, because the opcode register resets to 0x00, which is not on the default allow-list.
- R2: The opcode is held at byte address 0x45, is never stored in the FIFO, and is the first byte sent, most significant bit first.
- R3: After the opcode, the engine sends FIFO entries 0 to tx_count−1 in order (tx_count at byte address 0x48), MSB first. It then runs rx_count further bytes (rx_count at byte address 0x4B) with MOSI held at 0. The total is exactly 8·(1+tx_count+rx_count) SCK cycles.
- R4: The j-th received byte, MSB first, is stored in FIFO entry tx_count+j. The FIFO is readable and writable at byte addresses 0x80+i. Entries 0 to tx_count−1 keep their values.
- R5: A write to byte address 0x47 with bit 7 set starts one transaction when the engine is idle, the opcode is allowed and the lengths fit.
- R6: While a transaction runs, bit 7 of byte 0x4F (bit 31 of the status word at 0x4C) and bit 7 of byte 0x03 (bit 31 of the control word at 0x00) both read 1. They return to 0 at completion.
- R7: Bit 5 of byte 0x02 (bit 21 of the control word) reads 1 exactly when the stored opcode is not on the allow-list. A trigger given while it is 1 produces no chip-select activity and leaves busy at 0.
- R8: SPI mode 0 applies. SCK is low whenever chip select is high. MISO is sampled on rising SCK and MOSI changes after falling SCK. Chip select stays low from before the first rising edge until at least one full SCK period after the last falling edge.
- R9: While busy, a second trigger is ignored. Writes to the opcode, count and FIFO registers are also ignored.
- R10: A trigger with tx_count+rx_count greater than the FIFO depth is ignored.
- R11: With rx_count = 0, the transaction ends right after the last transmitted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for both read and write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for reg_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two things can meet in the same cycle: a software write arriving while the sequencer owns the FIFO and count registers, and a trigger arriving while a transaction is in flight. The bench provokes both in every transaction of a sweep over all transmit/receive count pairs that fit a small FIFO. Right after each trigger it writes a new opcode, a FIFO entry, a count and a second trigger. It judges the outcome from the serial bytes a flash model captures, from the chip-select fall count and from register readback. Exactly one transaction must appear, and nothing written during busy may stick.

// File: rtl/sfce_pkg.sv
package sfce_pkg;
   localparam logic [7:0] A_CTRL2 = 8'h02;
   localparam logic [7:0] A_CTRL3 = 8'h03;
   localparam logic [7:0] A_OPC   = 8'h45;
   localparam logic [7:0] A_TRIG  = 8'h47;
   localparam logic [7:0] A_TXC   = 8'h48;
   localparam logic [7:0] A_RXC   = 8'h4B;
   localparam logic [7:0] A_STAT3 = 8'h4F;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } seq_st_e;
endpackage

// File: rtl/sfce_allow.sv
module sfce_allow #(
   parameter int                      N_ALLOW = 6,
   parameter logic [N_ALLOW*8-1:0]    LIST    = '0
) (
   input  logic [7:0] opcode,
   output logic       hit
);
   logic [N_ALLOW-1:0] match;

   for (genvar i = 0; i < N_ALLOW; i++) begin : g_cmp
      assign match[i] = (opcode == LIST[i*8 +: 8]);
   end

   assign hit = |match;
endmodule

// File: rtl/sfce_fifo.sv
module sfce_fifo #(
   parameter int FIFO_DEPTH = 71,
   parameter int IDX_W      = 7
) (
   input  logic             clk,
   input  logic             we_a,
   input  logic [IDX_W-1:0] wa_a,
   input  logic [7:0]       wd_a,
   input  logic             we_b,
   input  logic [IDX_W-1:0] wa_b,
   input  logic [7:0]       wd_b,
   input  logic [IDX_W-1:0] ra_a,
   output logic [7:0]       rd_a,
   input  logic [IDX_W-1:0] ra_b,
   output logic [7:0]       rd_b
);
   logic [7:0] mem [FIFO_DEPTH];

   always_ff @(posedge clk) begin
      if (we_b)
         mem[wa_b] <= wd_b;
      else if (we_a)
         mem[wa_a] <= wd_a;
   end

   assign rd_a = mem[ra_a];
   assign rd_b = mem[ra_b];
endmodule

// File: rtl/sfce_shifter.sv
module sfce_shifter #(
   parameter int SCK_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] ld_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx_byte
);
   localparam int               DIV_W    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

   logic [7:0]       tx_sr, rx_sr;
   logic [DIV_W-1:0] div_q;
   logic [2:0]       bit_q;
   logic             act_q, sck_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr  <= '0;
         rx_sr  <= '0;
         div_q  <= '0;
         bit_q  <= '0;
         act_q  <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (ld) begin
            tx_sr <= ld_byte;
            div_q <= '0;
            bit_q <= '0;
            act_q <= 1'b1;
            sck_q <= 1'b0;
         end else if (act_q) begin
            if (div_q == DIV_LAST) begin
               div_q <= '0;
               if (!sck_q) begin
                  sck_q <= 1'b1;
                  rx_sr <= {rx_sr[6:0], miso};
               end else begin
                  sck_q <= 1'b0;
                  tx_sr <= {tx_sr[6:0], 1'b0};
                  if (bit_q == 3'd7) begin
                     act_q  <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 3'd1;
                  end
               end
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   end

   assign sck     = sck_q;
   assign mosi    = tx_sr[7];
   assign done    = done_q;
   assign rx_byte = rx_sr;
endmodule

// File: rtl/sfce_top.sv
module sfce_top
   import sfce_pkg::*;
#(
   parameter int                   FIFO_DEPTH = 71,
   parameter int                   SCK_HALF   = 2,
   parameter int                   N_ALLOW    = 6,
   parameter logic [N_ALLOW*8-1:0] ALLOW_LIST = {8'h03, 8'h0B, 8'h9F, 8'h05, 8'h06, 8'h02}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_cs_n,
   output logic       spi_sck,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int               IDX_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
   localparam int               TAIL_W    = $clog2(2 * SCK_HALF + 1);
   localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(2 * SCK_HALF - 1);

   if (FIFO_DEPTH < 1 || FIFO_DEPTH > 128) begin : g_bad_depth
      $error("sfce_top: FIFO_DEPTH must lie in 1..128");
   end
   if (SCK_HALF < 1) begin : g_bad_half
      $error("sfce_top: SCK_HALF must be at least 1");
   end
   if (N_ALLOW < 1) begin : g_bad_allow
      $error("sfce_top: N_ALLOW must be at least 1");
   end

   seq_st_e           st_q;
   logic [7:0]        opcode_q, tx_cnt_q, rx_cnt_q, k_q;
   logic [TAIL_W-1:0] tail_q;

   logic       busy, op_allowed, op_illegal, trig_wr, len_ok, go, ld;
   logic [8:0] last_k;
   logic [7:0] nk, nkm1, km1, ld_byte;
   logic       fifo_hit, fifo_in_rng, fifo_we_a, rx_store;
   logic [6:0] fifo_off;
   logic [7:0] fifo_rd_a, fifo_rd_b;
   logic       sh_done;
   logic [7:0] sh_rx;

   assign busy = (st_q != ST_IDLE);

   sfce_allow #(.N_ALLOW(N_ALLOW), .LIST(ALLOW_LIST)) u_allow (
      .opcode (opcode_q),
      .hit    (op_allowed)
   );
   assign op_illegal = !op_allowed;

   assign trig_wr = reg_we && (reg_addr == A_TRIG) && reg_wdata[7];
   assign last_k  = 9'(tx_cnt_q) + 9'(rx_cnt_q);
   assign len_ok  = (last_k <= 9'(FIFO_DEPTH));
   assign go      = trig_wr && !busy && !op_illegal && len_ok;

   // byte index k: 0 is the opcode, k>=1 maps to FIFO entry k-1
   assign nk      = go ? 8'd0 : (k_q + 8'd1);
   assign nkm1    = nk - 8'd1;
   assign km1     = k_q - 8'd1;
   assign ld      = go || ((st_q == ST_SHIFT) && sh_done && ({1'b0, k_q} != last_k));
   assign ld_byte = (nk == 8'd0)     ? opcode_q  :
                    (nk <= tx_cnt_q) ? fifo_rd_b : 8'h00;
   assign rx_store = (st_q == ST_SHIFT) && sh_done && (k_q > tx_cnt_q);

   assign fifo_hit    = reg_addr[7];
   assign fifo_off    = reg_addr[6:0];
   assign fifo_in_rng = ({1'b0, fifo_off} < 8'(FIFO_DEPTH));
   assign fifo_we_a   = reg_we && !busy && fifo_hit && fifo_in_rng;

   sfce_fifo #(.FIFO_DEPTH(FIFO_DEPTH), .IDX_W(IDX_W)) u_fifo (
      .clk  (clk),
      .we_a (fifo_we_a),
      .wa_a (fifo_off[IDX_W-1:0]),
      .wd_a (reg_wdata),
      .we_b (rx_store),
      .wa_b (km1[IDX_W-1:0]),
      .wd_b (sh_rx),
      .ra_a (fifo_off[IDX_W-1:0]),
      .rd_a (fifo_rd_a),
      .ra_b (nkm1[IDX_W-1:0]),
      .rd_b (fifo_rd_b)
   );

   sfce_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld),
      .ld_byte (ld_byte),
      .miso    (spi_miso),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .done    (sh_done),
      .rx_byte (sh_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= 8'h00;
         tx_cnt_q <= 8'h00;
         rx_cnt_q <= 8'h00;
      end else if (reg_we && !busy) begin
         if (reg_addr == A_OPC) opcode_q <= reg_wdata;
         if (reg_addr == A_TXC) tx_cnt_q <= reg_wdata;
         if (reg_addr == A_RXC) rx_cnt_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         k_q    <= '0;
         tail_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (go) begin
                  st_q <= ST_SHIFT;
                  k_q  <= '0;
               end
            end
            ST_SHIFT: begin
               if (sh_done) begin
                  if ({1'b0, k_q} == last_k) begin
                     st_q   <= ST_TAIL;
                     tail_q <= '0;
                  end else begin
                     k_q <= k_q + 8'd1;
                  end
               end
            end
            ST_TAIL: begin
               if (tail_q == TAIL_LAST) st_q <= ST_IDLE;
               else                     tail_q <= tail_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs_n = (st_q == ST_IDLE);

   always_comb begin
      reg_rdata = 8'h00;
      if (fifo_hit) begin
         if (fifo_in_rng) reg_rdata = fifo_rd_a;
      end else begin
         unique case (reg_addr)
            A_CTRL2: reg_rdata = {2'b00, op_illegal, 5'b00000};
            A_CTRL3: reg_rdata = {busy, 7'b0000000};
            A_STAT3: reg_rdata = {busy, 7'b0000000};
            A_OPC:   reg_rdata = opcode_q;
            A_TXC:   reg_rdata = tx_cnt_q;
            A_RXC:   reg_rdata = rx_cnt_q;
            default: reg_rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/sfce_chk.sv
module sfce_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_cs_n,
   input logic       spi_sck,
   input logic       busy,
   input logic       illegal,
   input logic       trig_wr,
   input logic [7:0] tx_cnt,
   input logic [7:0] rx_cnt
);
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);                                              // R8
   AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> $past(!spi_sck));                                 // R8
   AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig_wr && illegal) |=> (!busy && spi_cs_n));               // R7
   AST_START_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(trig_wr) && !$past(illegal)));                 // R5
   AST_COUNTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(tx_cnt) && $stable(rx_cnt)));                       // R9
endmodule

bind sfce_top sfce_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .spi_cs_n (spi_cs_n),
   .spi_sck  (spi_sck),
   .busy     (busy),
   .illegal  (op_illegal),
   .trig_wr  (trig_wr),
   .tx_cnt   (tx_cnt_q),
   .rx_cnt   (rx_cnt_q)
);

// File: tb/sfce_top_tb.sv
`timescale 1ns/100ps
module sfce_top_tb;
   localparam int DEPTH = 8;
   localparam int HALF  = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       spi_cs_n, spi_sck, spi_mosi;
   logic       spi_miso = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   sfce_top #(.FIFO_DEPTH(DEPTH), .SCK_HALF(HALF)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // flash model
   logic [7:0] cap [16];
   int         nbits = 0;
   int         csfalls = 0;
   int         sck_while_desel = 0;
   logic [7:0] seedv = 8'h00;
   realtime    t_lastfall = 0.0;
   realtime    t_csrise = 0.0;

   function automatic logic [7:0] resp(input int k, input logic [7:0] s);
      return 8'(k * 29 + 90) ^ s;
   endfunction
   function automatic logic [7:0] txd(input int i, input logic [7:0] s);
      return 8'(i * 7 + 1) + s;
   endfunction

   always @(negedge spi_cs_n) begin
      csfalls++;
      nbits = 0;
      spi_miso = resp(0, seedv)[7];
   end
   always @(posedge spi_cs_n) t_csrise = $realtime;
   always @(posedge spi_sck) begin
      if (spi_cs_n) sck_while_desel++;
      if (nbits < 128) cap[nbits / 8] = {cap[nbits / 8][6:0], spi_mosi};
      nbits++;
   end
   always @(negedge spi_sck) begin
      t_lastfall = $realtime;
      if (!spi_cs_n) spi_miso = resp(nbits / 8, seedv)[7 - (nbits % 8)];
   end

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] v;
      for (int n = 0; n < 2000; n++) begin
         rd(8'h4F, v);
         if (!v[7]) break;
      end
   endtask

   task automatic run_txn(input logic [7:0] op, input int tx, input int rx, input logic [7:0] s);
      logic [7:0] v;
      int c0;
      seedv = s;
      wr(8'h45, op);
      wr(8'h48, 8'(tx));
      wr(8'h4B, 8'(rx));
      for (int i = 0; i < tx; i++) wr(8'h80 + 8'(i), txd(i, s));
      c0 = csfalls;
      wr(8'h47, 8'h80);
      rd(8'h4F, v); check("R6 status busy", int'(v[7]), 1);
      rd(8'h03, v); check("R6 control busy", int'(v[7]), 1);
      // writes that collide with the running transaction: all must be dropped
      wr(8'h45, 8'h06);
      wr(8'h80, 8'hEE);
      wr(8'h47, 8'h80);
      wr(8'h48, 8'h05);
      wait_idle();
      repeat (8) @(negedge clk);
      check("R9 single transaction", csfalls - c0, 1);
      check("R3 R11 bit count", nbits, 8 * (1 + tx + rx));
      check("R2 opcode first", int'(cap[0]), int'(op));
      for (int i = 0; i < tx; i++)
         check("R3 tx byte", int'(cap[1 + i]), int'(txd(i, s)));
      for (int j = 0; j < rx; j++)
         check("R3 dummy mosi", int'(cap[1 + tx + j]), 0);
      rd(8'h45, v); check("R9 opcode kept", int'(v), int'(op));
      rd(8'h48, v); check("R9 tx count kept", int'(v), tx);
      for (int i = 0; i < tx; i++) begin
         rd(8'h80 + 8'(i), v); check("R4 tx entry kept", int'(v), int'(txd(i, s)));
      end
      for (int j = 0; j < rx; j++) begin
         rd(8'h80 + 8'(tx + j), v); check("R4 rx entry", int'(v), int'(resp(1 + tx + j, s)));
      end
      rd(8'h4F, v); check("R6 busy cleared", int'(v[7]), 0);
      check("R8 cs high at end", int'(spi_cs_n), 1);
      check("R8 cs hold", int'((t_csrise - t_lastfall) >= 2.0 * HALF * 5.0), 1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] ops [6];
      int c0;
      ops[0] = 8'h03; ops[1] = 8'h0B; ops[2] = 8'h9F;
      ops[3] = 8'h05; ops[4] = 8'h06; ops[5] = 8'h02;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 cs_n", int'(spi_cs_n), 1);
      check("R1 sck", int'(spi_sck), 0);
      rd(8'h4F, v); check("R1 status busy", int'(v[7]), 0);
      rd(8'h03, v); check("R1 control busy", int'(v[7]), 0);
      rd(8'h02, v); check("R1 illegal", int'(v[5]), 1);

      // R7 opcode screening
      wr(8'h48, 8'h00); wr(8'h4B, 8'h01);
      wr(8'h45, 8'h20);
      rd(8'h02, v); check("R7 illegal set", int'(v[5]), 1);
      c0 = csfalls;
      wr(8'h47, 8'h80);
      repeat (30) @(negedge clk);
      check("R7 blocked no select", csfalls - c0, 0);
      rd(8'h4F, v); check("R7 blocked not busy", int'(v[7]), 0);
      wr(8'h45, 8'h9F);
      rd(8'h02, v); check("R7 illegal clear", int'(v[5]), 0);

      // R5 trigger bit 7 clear does nothing
      c0 = csfalls;
      wr(8'h47, 8'h7F);
      repeat (20) @(negedge clk);
      check("R5 bit7 required", csfalls - c0, 0);

      // R10 length limits
      wr(8'h48, 8'(3)); wr(8'h4B, 8'(DEPTH - 2));
      c0 = csfalls;
      wr(8'h47, 8'h80);
      repeat (30) @(negedge clk);
      check("R10 sum overflow", csfalls - c0, 0);
      wr(8'h48, 8'(DEPTH + 1)); wr(8'h4B, 8'h00);
      wr(8'h47, 8'h80);
      repeat (30) @(negedge clk);
      check("R10 tx overflow", csfalls - c0, 0);

      // sweep over every fitting count pair
      for (int tx = 0; tx <= DEPTH; tx++)
         for (int rx = 0; rx <= DEPTH - tx; rx++)
            run_txn(ops[(tx + rx) % 6], tx, rx, 8'(tx * 16 + rx));

      check("R8 no sck while deselected", sck_while_desel, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule